// File: doc/BRIEF.md
# Power-over-Ethernet Port Sequencer

This block steps a group of Ethernet power ports (four by default) through signature detection, classification and power-on without a host. A single shared measurement channel serves every port. For each step the sequencer issues a start pulse, names the port and the kind of measurement (signature resistance or classification current), and then waits for a done pulse carrying a digital code. A resistance code inside a configurable acceptance window passes the port on to classification. The classification current is decoded into a class code from five thresholds. The port is then powered.

After reset the sequencer stays in a hold-off period of a configurable number of clock cycles. In managed mode it starts no new measurements. Per-port enables and a global disable decide whether a port may be probed or stay powered. A fault reported on a powered port is latched until a clear command arrives for that port. After a rejected signature the sequencer either moves straight on or first waits through a configurable back-off period.

Sequencer states: `SQ_HOLD` (post-reset hold-off), `SQ_SCAN` (looks for an eligible port), `SQ_DET_REQ` / `SQ_DET_WAIT` (resistance measurement), `SQ_CLS_REQ` / `SQ_CLS_WAIT` (current measurement) and `SQ_BACKOFF`. The transitions are: HOLD→SCAN when the hold-off timer expires. SCAN→DET_REQ when the port under the pointer is OFF, enabled and the mode is auto; otherwise the pointer advances. DET_REQ→DET_WAIT. DET_WAIT→CLS_REQ on an accepted code. DET_WAIT→BACKOFF or →SCAN on a rejected code. CLS_REQ→CLS_WAIT. CLS_WAIT→SCAN on done. BACKOFF→SCAN when the back-off timer expires.

Top module: `poe_port_seq`

## Requirements
- R1: While reset is held, and at the first sample after it is released, every port state reads OFF (code 0) and `det_en`, `cls_en`, `pwr_en` and `meas_start` are all zero.
- R2: The first `meas_start` comes no earlier than HOLD_CYC cycles after reset release, and no later than HOLD_CYC+8 cycles after release when port 0 is enabled in auto mode.
- R3: While `mode_mgmt` is 1, no `meas_start` is issued and no port leaves OFF.
- R4: A resistance code C is accepted when R_LO ≤ C ≤ R_HI (port state goes to CLASSIFY, code 2). Any other code returns the port to OFF (code 0).
- R5: A current code I decodes to class 0 when I < T1, 1 when T1 ≤ I < T2, 2 when T2 ≤ I < T3, 3 when T3 ≤ I < T4, 4 when T4 ≤ I < T5, and 0 when I ≥ T5. The port then reads POWERED (code 3) with `pwr_en` set.
- R6: When `backoff_sel` is 0, a rejected port is probed again within 12 cycles if it is the only enabled port. When `backoff_sel` is 1, the next probe comes no earlier than BACKOFF_CYC cycles later.
- R7: A port whose enable bit is 0, or any port while `all_dis` is 1, is never probed. A powered port drops to OFF with `pwr_en` 0 one cycle after either condition appears.
- R8: A pulse on `fault_in[i]` while port i is POWERED moves it to FAULT (code 4) with `pwr_en[i]` 0. FAULT holds through enable changes and leaves only on `clr_fault[i]`, which returns the port to OFF.
- R9: Only one port is probed at a time (`det_en`/`cls_en` together at most one-hot). Eligible ports are visited in ascending index order, wrapping from NPORT-1 to 0. `meas_kind` is 0 for resistance and 1 for current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset |
| mode_mgmt | input | 1 | 1 = managed mode, no autonomous probing |
| backoff_sel | input | 1 | 1 = wait BACKOFF_CYC cycles after a rejected signature |
| port_en | input | NPORT | Per-port enable |
| all_dis | input | 1 | Disable all ports |
| fault_in | input | NPORT | Fault indication per port |
| clr_fault | input | NPORT | Disable command per port, clears a latched fault |
| meas_done | input | 1 | Measurement result valid (one cycle) |
| meas_code | input | CW | Measurement result code |
| meas_start | output | 1 | Start pulse for the shared measurement channel |
| meas_kind | output | 1 | 0 resistance, 1 current |
| meas_port | output | PW | Port being measured |
| det_en | output | NPORT | Detection drive, per port |
| cls_en | output | NPORT | Classification drive, per port |
| pwr_en | output | NPORT | Power switch enable, per port |
| port_state | output | NPORT*3 | Per-port state code, port i at bits 3i+2..3i |
| port_class | output | NPORT*3 | Per-port class code, port i at bits 3i+2..3i |

## Verification
Resistance codes are placed on both sides of each window edge (R_LO-1, R_LO, R_HI, R_HI+1). These separate an off-by-one window from a correct one. Current codes sit just below and exactly on every class threshold, and one is well past the top. This shows whether each band edge is inclusive and whether the wrap back to class 0 is present. Repeated rejections with the back-off select low and then high compare the time between probes. With all four ports enabled, the recorded probe order exposes pointer and wrap mistakes. A fault followed by enable toggling and a clear shows whether the fault is truly latched.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;
    typedef enum logic [2:0] {
        PS_OFF      = 3'd0,
        PS_DETECT   = 3'd1,
        PS_CLASSIFY = 3'd2,
        PS_POWERED  = 3'd3,
        PS_FAULT    = 3'd4
    } port_st_e;

    typedef enum logic [2:0] {
        SQ_HOLD, SQ_SCAN, SQ_DET_REQ, SQ_DET_WAIT, SQ_CLS_REQ, SQ_CLS_WAIT, SQ_BACKOFF
    } seq_st_e;
endpackage

// File: rtl/poe_seq_tmr.sv
module poe_seq_tmr #(
    parameter int CYC         = 8,
    parameter bit START_ARMED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int W = $clog2(CYC + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= START_ARMED ? W'(CYC) : '0;
        else if (arm)        cnt <= W'(CYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/poe_seq_rwin.sv
module poe_seq_rwin #(
    parameter int CW   = 15,
    parameter int R_LO = 190,
    parameter int R_HI = 265
) (
    input  logic [CW-1:0] code,
    output logic          ok
);
    assign ok = (code >= CW'(R_LO)) && (code <= CW'(R_HI));
endmodule

// File: rtl/poe_seq_cdec.sv
module poe_seq_cdec #(
    parameter int CW = 15,
    parameter int T1 = 65,
    parameter int T2 = 145,
    parameter int T3 = 230,
    parameter int T4 = 330,
    parameter int T5 = 480
) (
    input  logic [CW-1:0] code,
    output logic [2:0]    cls
);
    always_comb begin
        if      (code < CW'(T1)) cls = 3'd0;
        else if (code < CW'(T2)) cls = 3'd1;
        else if (code < CW'(T3)) cls = 3'd2;
        else if (code < CW'(T4)) cls = 3'd3;
        else if (code < CW'(T5)) cls = 3'd4;
        else                     cls = 3'd0;
    end
endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
    import poe_seq_pkg::*;
#(
    parameter int NPORT       = 4,
    parameter int CW          = 15,
    parameter int HOLD_CYC    = 66000,
    parameter int BACKOFF_CYC = 490000,
    parameter int R_LO        = 190,
    parameter int R_HI        = 265,
    parameter int T1          = 65,
    parameter int T2          = 145,
    parameter int T3          = 230,
    parameter int T4          = 330,
    parameter int T5          = 480,
    localparam int PW         = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_mgmt,
    input  logic               backoff_sel,
    input  logic [NPORT-1:0]   port_en,
    input  logic               all_dis,
    input  logic [NPORT-1:0]   fault_in,
    input  logic [NPORT-1:0]   clr_fault,
    input  logic               meas_done,
    input  logic [CW-1:0]      meas_code,
    output logic               meas_start,
    output logic               meas_kind,
    output logic [PW-1:0]      meas_port,
    output logic [NPORT-1:0]   det_en,
    output logic [NPORT-1:0]   cls_en,
    output logic [NPORT-1:0]   pwr_en,
    output logic [NPORT*3-1:0] port_state,
    output logic [NPORT*3-1:0] port_class
);
    localparam logic [PW-1:0] LAST = PW'(NPORT - 1);

    seq_st_e       sq, sq_nxt;
    logic [PW-1:0] ptr, ptr_nxt, ptr_inc;
    port_st_e      ps     [NPORT];
    port_st_e      ps_nxt [NPORT];
    logic [2:0]    cls_q  [NPORT];
    logic          hold_exp, bo_exp, bo_arm, r_ok, elig;
    logic [2:0]    cls_dec;

    poe_seq_tmr #(.CYC(HOLD_CYC), .START_ARMED(1'b1)) u_hold (
        .clk(clk), .rst_n(rst_n), .arm(1'b0), .expired(hold_exp));
    poe_seq_tmr #(.CYC(BACKOFF_CYC), .START_ARMED(1'b0)) u_backoff (
        .clk(clk), .rst_n(rst_n), .arm(bo_arm), .expired(bo_exp));
    poe_seq_rwin #(.CW(CW), .R_LO(R_LO), .R_HI(R_HI)) u_rwin (
        .code(meas_code), .ok(r_ok));
    poe_seq_cdec #(.CW(CW), .T1(T1), .T2(T2), .T3(T3), .T4(T4), .T5(T5)) u_cdec (
        .code(meas_code), .cls(cls_dec));

    assign ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
    assign elig    = port_en[ptr] && !all_dis;

    // sequencer next state
    always_comb begin
        sq_nxt  = sq;
        ptr_nxt = ptr;
        bo_arm  = 1'b0;
        unique case (sq)
            SQ_HOLD:     if (hold_exp) sq_nxt = SQ_SCAN;
            SQ_SCAN: if (!mode_mgmt) begin
                if (ps[ptr] == PS_OFF && elig) sq_nxt = SQ_DET_REQ;
                else                           ptr_nxt = ptr_inc;
            end
            SQ_DET_REQ:  sq_nxt = SQ_DET_WAIT;
            SQ_DET_WAIT: if (meas_done) begin
                if (r_ok && elig) sq_nxt = SQ_CLS_REQ;
                else if (backoff_sel) begin
                    bo_arm = 1'b1;
                    sq_nxt = SQ_BACKOFF;
                end else begin
                    ptr_nxt = ptr_inc;
                    sq_nxt  = SQ_SCAN;
                end
            end
            SQ_CLS_REQ:  sq_nxt = SQ_CLS_WAIT;
            SQ_CLS_WAIT: if (meas_done) begin
                ptr_nxt = ptr_inc;
                sq_nxt  = SQ_SCAN;
            end
            SQ_BACKOFF: if (bo_exp) begin
                ptr_nxt = ptr_inc;
                sq_nxt  = SQ_SCAN;
            end
            default:     sq_nxt = SQ_HOLD;
        endcase
    end

    // per-port next state: own events first, sequencer steps override
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            ps_nxt[i] = ps[i];
            if (ps[i] == PS_POWERED) begin
                if (fault_in[i])                  ps_nxt[i] = PS_FAULT;
                else if (!port_en[i] || all_dis)  ps_nxt[i] = PS_OFF;
            end else if (ps[i] == PS_FAULT && clr_fault[i]) begin
                ps_nxt[i] = PS_OFF;
            end
        end
        if (sq == SQ_DET_REQ)
            ps_nxt[ptr] = PS_DETECT;
        else if (sq == SQ_DET_WAIT && meas_done)
            ps_nxt[ptr] = (r_ok && elig) ? PS_CLASSIFY : PS_OFF;
        else if (sq == SQ_CLS_WAIT && meas_done)
            ps_nxt[ptr] = elig ? PS_POWERED : PS_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq  <= SQ_HOLD;
            ptr <= '0;
        end else begin
            sq  <= sq_nxt;
            ptr <= ptr_nxt;
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ps[g]    <= PS_OFF;
                cls_q[g] <= 3'd0;
            end else begin
                ps[g] <= ps_nxt[g];
                if (sq == SQ_CLS_WAIT && meas_done && ptr == PW'(g))
                    cls_q[g] <= cls_dec;
            end
        end
    end

    // outputs
    always_comb begin
        meas_start = (sq == SQ_DET_REQ) || (sq == SQ_CLS_REQ);
        meas_kind  = (sq == SQ_CLS_REQ) || (sq == SQ_CLS_WAIT);
        meas_port  = ptr;
        for (int i = 0; i < NPORT; i++) begin
            det_en[i] = (sq == SQ_DET_REQ || sq == SQ_DET_WAIT) && ptr == PW'(i);
            cls_en[i] = (sq == SQ_CLS_REQ || sq == SQ_CLS_WAIT) && ptr == PW'(i);
            pwr_en[i] = (ps[i] == PS_POWERED);
            port_state[i*3 +: 3] = ps[i];
            port_class[i*3 +: 3] = cls_q[i];
        end
    end
endmodule

// File: rtl/poe_port_seq_chk.sv
module poe_port_seq_chk
    import poe_seq_pkg::*;
#(
    parameter int NPORT    = 4,
    parameter int HOLD_CYC = 66000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mode_mgmt,
    input logic               all_dis,
    input logic [NPORT-1:0]   clr_fault,
    input logic               meas_start,
    input logic [NPORT-1:0]   det_en,
    input logic [NPORT-1:0]   cls_en,
    input logic [NPORT-1:0]   pwr_en,
    input logic [NPORT*3-1:0] port_state
);
    localparam int SW = $clog2(HOLD_CYC + 1);
    logic [SW-1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       since_rst <= '0;
        else if (since_rst != SW'(HOLD_CYC)) since_rst <= since_rst + 1'b1;
    end

    // R2
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |-> since_rst == SW'(HOLD_CYC));

    // R3
    managed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |-> !$past(mode_mgmt));

    // R9
    one_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({det_en, cls_en}));

    // R7
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_dis |=> pwr_en == '0);

    for (genvar g = 0; g < NPORT; g++) begin : g_fault
        // R8
        fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (port_state[g*3 +: 3] == 3'(PS_FAULT) && !clr_fault[g])
            |=> port_state[g*3 +: 3] == 3'(PS_FAULT));
    end
endmodule

bind poe_port_seq poe_port_seq_chk #(.NPORT(NPORT), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_mgmt(mode_mgmt), .all_dis(all_dis),
    .clr_fault(clr_fault), .meas_start(meas_start), .det_en(det_en),
    .cls_en(cls_en), .pwr_en(pwr_en), .port_state(port_state));

// File: tb/poe_port_seq_test.sv
module poe_port_seq_test;
    localparam int NP = 4, CW = 15, HOLD = 20, BO = 40;
    localparam int RLO = 190, RHI = 265;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_mgmt = 1'b0, backoff_sel = 1'b0, all_dis = 1'b0, meas_done = 1'b0;
    logic [NP-1:0] port_en = '0, fault_in = '0, clr_fault = '0;
    logic [CW-1:0] meas_code = '0;
    logic meas_start, meas_kind;
    logic [1:0] meas_port;
    logic [NP-1:0] det_en, cls_en, pwr_en;
    logic [NP*3-1:0] port_state, port_class;
    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    poe_port_seq #(.NPORT(NP), .CW(CW), .HOLD_CYC(HOLD), .BACKOFF_CYC(BO),
                   .R_LO(RLO), .R_HI(RHI)) uut (
        .clk(clk), .rst_n(rst_n), .mode_mgmt(mode_mgmt), .backoff_sel(backoff_sel),
        .port_en(port_en), .all_dis(all_dis), .fault_in(fault_in), .clr_fault(clr_fault),
        .meas_done(meas_done), .meas_code(meas_code), .meas_start(meas_start),
        .meas_kind(meas_kind), .meas_port(meas_port), .det_en(det_en), .cls_en(cls_en),
        .pwr_en(pwr_en), .port_state(port_state), .port_class(port_class));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pst(input int p);
        return int'(port_state[p*3 +: 3]);
    endfunction

    function automatic int pcl(input int p);
        return int'(port_class[p*3 +: 3]);
    endfunction

    // waits at negedges for a start pulse; leaves one negedge past it
    task automatic wait_start(output int port, output int kind, output int gap);
        gap = 0;
        while (!meas_start && gap < 300) begin
            @(negedge clk);
            gap++;
        end
        port = meas_start ? int'(meas_port) : -1;
        kind = int'(meas_kind);
        @(negedge clk);
    endtask

    task automatic respond(input int code);
        repeat (2) @(negedge clk);
        meas_code = CW'(code);
        meas_done = 1'b1;
        @(negedge clk);
        meas_done = 1'b0;
    endtask

    task automatic do_reset(input bit mgmt);
        rst_n = 1'b0;
        mode_mgmt = mgmt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1, R3
    task automatic t_reset_managed();
        int starts = 0, moved = 0;
        do_reset(1'b1);
        port_en = '1;
        chk(port_state == '0, "R1 states", int'(port_state), 0);
        chk({det_en, cls_en, pwr_en, meas_start} == '0, "R1 drives",
            int'({det_en, cls_en, pwr_en}), 0);
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (meas_start) starts++;
            if (port_state != '0) moved++;
        end
        chk(starts == 0, "R3 no start in managed mode", starts, 0);
        chk(moved == 0, "R3 ports stay off", moved, 0);
        port_en = '0;
    endtask

    // R2: first probe after hold-off; rejected low code
    task automatic t_holdoff();
        int port, kind, gap;
        port_en = 4'b0001;
        do_reset(1'b0);
        wait_start(port, kind, gap);
        gap++;
        chk(gap >= HOLD && gap <= HOLD + 8, "R2 hold-off length", gap, HOLD);
        chk(port == 0 && kind == 0, "R9 first probe port0 resistance", port, 0);
        respond(RLO - 1);
        chk(pst(0) == 0, "R4 below window rejected", pst(0), 0);
        port_en = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic trial(input int p, input int rcode, input int icode,
                         input bit acc, input int ecls, input string tag);
        int port, kind, gap;
        port_en = NP'(1) << p;
        wait_start(port, kind, gap);
        chk(port == p && kind == 0, {tag, " R9 detect port"}, port, p);
        respond(rcode);
        if (acc) begin
            chk(pst(p) == 2, {tag, " R4 accepted"}, pst(p), 2);
            wait_start(port, kind, gap);
            chk(port == p && kind == 1, {tag, " R9 classify port"}, kind, 1);
            respond(icode);
            chk(pst(p) == 3 && pwr_en[p], {tag, " R5 powered"}, pst(p), 3);
            chk(pcl(p) == ecls, {tag, " R5 class"}, pcl(p), ecls);
            port_en = '0;
            @(negedge clk);
            chk(pst(p) == 0 && !pwr_en[p], {tag, " R7 enable drop"}, pst(p), 0);
        end else begin
            chk(pst(p) == 0, {tag, " R4 rejected"}, pst(p), 0);
            port_en = '0;
        end
        repeat (4) @(negedge clk);
    endtask

    // R4 window edges
    task automatic t_window();
        trial(1, RLO, 100, 1'b1, 1, "R4 lo edge");
        trial(2, RHI, 100, 1'b1, 1, "R4 hi edge");
        trial(3, RHI + 1, 0, 1'b0, 0, "R4 above");
    endtask

    // R5 class bands
    task automatic t_class();
        trial(0, 220, 64, 1'b1, 0, "R5 c0");
        trial(1, 220, 65, 1'b1, 1, "R5 t1");
        trial(2, 220, 145, 1'b1, 2, "R5 t2");
        trial(3, 220, 229, 1'b1, 2, "R5 below t3");
        trial(0, 220, 230, 1'b1, 3, "R5 t3");
        trial(1, 220, 330, 1'b1, 4, "R5 t4");
        trial(2, 220, 479, 1'b1, 4, "R5 below t5");
        trial(3, 220, 480, 1'b1, 0, "R5 t5 wraps");
        trial(0, 220, 900, 1'b1, 0, "R5 far above");
    endtask

    // R6 back-off
    task automatic t_backoff();
        int port, kind, gap;
        backoff_sel = 1'b0;
        port_en = 4'b0010;
        wait_start(port, kind, gap);
        respond(50);
        wait_start(port, kind, gap);
        chk(port == 1 && gap < 12, "R6 immediate retry", gap, 12);
        backoff_sel = 1'b1;
        respond(50);
        wait_start(port, kind, gap);
        chk(port == 1 && gap >= BO && gap <= BO + 14, "R6 back-off wait", gap, BO);
        respond(400);
        port_en = '0;
        repeat (BO + 8) @(negedge clk);
        backoff_sel = 1'b0;
    endtask

    // R9 order, R8 fault latch, R7 global disable
    task automatic t_all_ports();
        int port, kind, gap, first = 0, starts = 0;
        port_en = '1;
        for (int k = 0; k < NP; k++) begin
            wait_start(port, kind, gap);
            if (k == 0) first = port;
            chk(port == (first + k) % NP && kind == 0, "R9 ascending order", port,
                (first + k) % NP);
            respond(220);
            wait_start(port, kind, gap);
            respond(100);
        end
        chk(port_state == 12'b011_011_011_011 && pwr_en == '1, "R9 all powered",
            int'(port_state), 12'b011_011_011_011);
        fault_in[2] = 1'b1;
        @(negedge clk);
        fault_in[2] = 1'b0;
        chk(pst(2) == 4 && !pwr_en[2], "R8 fault latched", pst(2), 4);
        port_en[2] = 1'b0;
        repeat (2) @(negedge clk);
        port_en[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk(pst(2) == 4, "R8 survives enable toggle", pst(2), 4);
        clr_fault[2] = 1'b1;
        @(negedge clk);
        clr_fault[2] = 1'b0;
        chk(pst(2) == 0, "R8 clear returns off", pst(2), 0);
        wait_start(port, kind, gap);
        chk(port == 2, "R8 redetected after clear", port, 2);
        respond(220);
        wait_start(port, kind, gap);
        respond(250);
        chk(pst(2) == 3 && pcl(2) == 3, "R8 repowered class3", pcl(2), 3);
        all_dis = 1'b1;
        @(negedge clk);
        chk(port_state == '0 && pwr_en == '0, "R7 all disable", int'(port_state), 0);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (meas_start) starts++;
        end
        chk(starts == 0, "R7 no probe while disabled", starts, 0);
        port_en = '0;
        all_dis = 1'b0;
        repeat (4) @(negedge clk);
        chk(port_state == '0, "R7 disabled ports idle", int'(port_state), 0);
    endtask

    initial begin
        t_reset_managed();
        t_holdoff();
        t_window();
        t_class();
        t_backoff();
        t_all_ports();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule